// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block steps a small processor subsystem between three power modes: Run, Idle and Sleep. A one-cycle request strobe carries a mode operand, as a decoded power-save instruction would. The controller then produces the clock-gate enables for the CPU, for each peripheral, for the main oscillator and for the low-power RC oscillator. It also produces the watchdog clear pulse, the enable for the clock-failure monitor, and the clock-source selection to resume with after Sleep.

Idle stops only the CPU clock. Sleep stops the CPU, the main oscillator and the clock monitor. In Sleep, peripherals keep their clock only if they run from their own external clock. The low-power RC oscillator stays on in Sleep only while the watchdog is enabled. Before the gates close on the way into Sleep, the block clears the watchdog. It also captures the selected clock-source code at that point and presents it again on wake.

An enabled interrupt or a watchdog time-out wakes the block from either low-power mode. A reset returns it to Run from any state. A wake-cause code records what ended the last low-power period.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A request with `req_op_i`=1 (sleep) accepted in Run gives one entry cycle in which `pm_mode_o`=2'b00 and the CPU and main-oscillator enables are still high. In the next cycle `pm_mode_o`=2'b10 and `cpu_clk_en_o` and `osc_en_o` are both low.
- R2: A request with `req_op_i`=0 (idle) accepted in Run gives, from the next cycle, `pm_mode_o`=2'b01 with `cpu_clk_en_o` low and `osc_en_o` and every bit of `periph_clk_en_o` high.
- R3: In Idle or Sleep, `irq_pend_i` or `wdt_tmo_i` high at a clock edge starts the wake. From Idle the block is back in Run (2'b00, CPU enabled) in the next cycle. `rst_n` low at an edge returns the block to Run from any state.
- R4: `wdt_clr_o` is high for exactly the one Sleep entry cycle, and only when `wdt_en_i` is high. It is low in every other cycle.
- R5: While `pm_mode_o`=2'b10, `lprc_en_o` equals `wdt_en_i`. In all other modes it is high.
- R6: `clk_mon_en_o` is low whenever `pm_mode_o`=2'b10 and high otherwise.
- R7: While `pm_mode_o`=2'b10, bit k of `periph_clk_en_o` equals bit k of `periph_extclk_i`. In all other modes every bit is high.
- R8: `clk_src_o` takes the value of `clk_src_i` at the edge that accepts a sleep request. It holds that value through Sleep, the wake cycle and the first Run cycle after wake. At all other times it follows `clk_src_i` one cycle late.
- R9: During and right after reset, `pm_mode_o`=2'b00, every enable output is high, `wdt_clr_o` is low, `wake_cause_o`=2'b11 and `clk_src_o`=3'b000.
- R10: A request made in Run while `irq_pend_i` is high is not accepted. The block stays in Run with the CPU clock enabled, and `wake_cause_o` is unchanged.
- R11: Wake from Sleep takes two cycles. In the first, `osc_en_o` is high, `cpu_clk_en_o` is low and `pm_mode_o` is still 2'b10. In the second, the block is in Run with every enable high.
- R12: `wake_cause_o` is set at the wake edge: 2'b01 for an interrupt (an interrupt wins when it arrives together with a time-out) and 2'b10 for a watchdog time-out. An accepted request clears it to 2'b00, and it holds in every other cycle.
- R13: A request that arrives while the block is in Idle or Sleep has no effect on the mode or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld_i | input | 1 | One-cycle power-save request strobe |
| req_op_i | input | 1 | Request operand: 1 = sleep, 0 = idle |
| irq_pend_i | input | 1 | An individually enabled interrupt is pending |
| wdt_tmo_i | input | 1 | Watchdog time-out |
| wdt_en_i | input | 1 | Watchdog enable |
| clk_src_i | input | SRC_W | Currently selected clock-source code |
| periph_extclk_i | input | NUM_PERIPH | Per-peripheral flag: peripheral runs from its own external clock |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| periph_clk_en_o | output | NUM_PERIPH | Per-peripheral clock gate enables |
| osc_en_o | output | 1 | Main oscillator enable |
| lprc_en_o | output | 1 | Low-power RC oscillator enable |
| wdt_clr_o | output | 1 | One-cycle watchdog clear pulse |
| clk_mon_en_o | output | 1 | Clock-failure monitor enable |
| clk_src_o | output | SRC_W | Clock-source code to run from (held across Sleep) |
| wake_cause_o | output | 2 | 01 interrupt, 10 watchdog, 11 reset, 00 cleared |
| pm_mode_o | output | 2 | 00 Run, 01 Idle, 10 Sleep |

## Verification
A vector table sends the block through Sleep and Idle with the watchdog enable both on and off, with peripheral external-clock masks of all-zero, all-one and mixed, and with wakes caused by an interrupt alone, a time-out alone and both together. Each vector uses a distinct clock-source code. These combinations separate the Sleep gating from the Idle gating, show that the watchdog clear and the low-power RC enable follow the watchdog bit, and show that the wake-cause priority is applied. Changing the source code while the block is asleep shows whether the restored value really comes from the entry capture or simply follows the input. Directed cases cover a request blocked by a pending interrupt, a request made while already in a low-power mode, a reset during Sleep, and live changes to the watchdog and external-clock inputs during Sleep.

// File: rtl/pwr_mode_pkg.sv
// Shared types for the power-mode controller.
// Assumes: the mode encoding below is seen by neighbouring logic; the
// internal state encoding is private to the controller.
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_IDLE  = 2'b01,
        PM_SLEEP = 2'b10
    } pm_mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE,
        ST_SLP_ENTRY,
        ST_SLEEP,
        ST_SLP_WAKE
    } pm_state_e;

    typedef enum logic [1:0] {
        WK_NONE = 2'b00,
        WK_IRQ  = 2'b01,
        WK_WDT  = 2'b10,
        WK_RST  = 2'b11
    } wake_cause_e;

    localparam logic OP_IDLE  = 1'b0;
    localparam logic OP_SLEEP = 1'b1;

    // Map an internal state onto the externally visible mode.
    function automatic pm_mode_e state_to_mode(input pm_state_e st);
        case (st)
            ST_IDLE:                 return PM_IDLE;
            ST_SLEEP, ST_SLP_WAKE:   return PM_SLEEP;
            default:                 return PM_RUN;
        endcase
    endfunction

endpackage

// File: rtl/pmc_fsm.sv
// Mode sequencer: accepts power-save requests, walks the two-step Sleep
// entry and the two-step Sleep wake, and records the wake cause.
// Assumes: req_vld_i is a single-cycle strobe; rst_n is synchronous.
module pmc_fsm
    import pwr_mode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_vld_i,
    input  logic        req_op_i,
    input  logic        irq_pend_i,
    input  logic        wdt_tmo_i,
    output pm_state_e   state_o,
    output logic        accept_o,
    output wake_cause_e cause_o
);

    pm_state_e   state_q, state_d;
    wake_cause_e cause_q;
    logic        wake_evt;
    logic        low_pwr;

    assign wake_evt = irq_pend_i | wdt_tmo_i;
    assign low_pwr  = (state_q == ST_IDLE) || (state_q == ST_SLEEP);
    assign accept_o = (state_q == ST_RUN) && req_vld_i && !irq_pend_i;

    // Next-state selection for the mode sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN: begin
                if (accept_o)
                    state_d = (req_op_i == OP_SLEEP) ? ST_SLP_ENTRY : ST_IDLE;
            end
            ST_IDLE:      if (wake_evt) state_d = ST_RUN;
            ST_SLP_ENTRY: state_d = ST_SLEEP;
            ST_SLEEP:     if (wake_evt) state_d = ST_SLP_WAKE;
            ST_SLP_WAKE:  state_d = ST_RUN;
            default:      state_d = ST_RUN;
        endcase
    end

    // State register, reset into Run.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Wake-cause register: set on wake, cleared on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= WK_RST;
        else if (accept_o)
            cause_q <= WK_NONE;
        else if (low_pwr && wake_evt)
            cause_q <= irq_pend_i ? WK_IRQ : WK_WDT;
    end

    assign state_o = state_q;
    assign cause_o = cause_q;

endmodule

// File: rtl/pmc_src_hold.sv
// Clock-source capture: follows the selected source code while the
// system is clocked and freezes it from Sleep acceptance until wake.
// Assumes: track_i is high exactly in the Run and Idle states.
module pmc_src_hold #(
    parameter int SRC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             track_i,
    input  logic [SRC_W-1:0] src_i,
    output logic [SRC_W-1:0] src_o
);

    logic [SRC_W-1:0] src_q;

    // Load the live code while tracking, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       src_q <= '0;
        else if (track_i) src_q <= src_i;
    end

    assign src_o = src_q;

endmodule

// File: rtl/pmc_gate_dec.sv
// Gate decoder: turns the controller state into clock, oscillator,
// monitor and watchdog-clear enables.
// Assumes: outputs feed glitch-safe clock-gate cells downstream.
module pmc_gate_dec
    import pwr_mode_pkg::*;
#(
    parameter int NUM_PERIPH = 4
) (
    input  pm_state_e               state_i,
    input  logic                    wdt_en_i,
    input  logic [NUM_PERIPH-1:0]   extclk_i,
    output logic                    cpu_en_o,
    output logic [NUM_PERIPH-1:0]   periph_en_o,
    output logic                    osc_en_o,
    output logic                    lprc_en_o,
    output logic                    wdt_clr_o,
    output logic                    mon_en_o,
    output pm_mode_e                mode_o
);

    logic sys_clk_off;

    assign sys_clk_off = (state_i == ST_SLEEP) || (state_i == ST_SLP_WAKE);

    // Core and oscillator enables derived from the state.
    always_comb begin
        cpu_en_o  = (state_i == ST_RUN) || (state_i == ST_SLP_ENTRY);
        osc_en_o  = (state_i != ST_SLEEP);
        lprc_en_o = sys_clk_off ? wdt_en_i : 1'b1;
        wdt_clr_o = (state_i == ST_SLP_ENTRY) && wdt_en_i;
        mon_en_o  = !sys_clk_off;
        mode_o    = state_to_mode(state_i);
    end

    // One gate per peripheral; an external clock keeps it alive in Sleep.
    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_periph
        assign periph_en_o[g] = sys_clk_off ? extclk_i[g] : 1'b1;
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Power-mode controller top: Run / Idle / Sleep sequencing with clock
// gate enables, watchdog clear on Sleep entry and clock-source restore.
// Assumes: all inputs are synchronous to clk; clk itself is never gated.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int SRC_W      = 3,
    parameter int NUM_PERIPH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_vld_i,
    input  logic                  req_op_i,
    input  logic                  irq_pend_i,
    input  logic                  wdt_tmo_i,
    input  logic                  wdt_en_i,
    input  logic [SRC_W-1:0]      clk_src_i,
    input  logic [NUM_PERIPH-1:0] periph_extclk_i,
    output logic                  cpu_clk_en_o,
    output logic [NUM_PERIPH-1:0] periph_clk_en_o,
    output logic                  osc_en_o,
    output logic                  lprc_en_o,
    output logic                  wdt_clr_o,
    output logic                  clk_mon_en_o,
    output logic [SRC_W-1:0]      clk_src_o,
    output logic [1:0]            wake_cause_o,
    output logic [1:0]            pm_mode_o
);

    pm_state_e   fsm_state;
    wake_cause_e fsm_cause;
    pm_mode_e    dec_mode;
    logic        fsm_accept;
    logic        src_track;

    pmc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_vld_i  (req_vld_i),
        .req_op_i   (req_op_i),
        .irq_pend_i (irq_pend_i),
        .wdt_tmo_i  (wdt_tmo_i),
        .state_o    (fsm_state),
        .accept_o   (fsm_accept),
        .cause_o    (fsm_cause)
    );

    assign src_track = (fsm_state == ST_RUN) || (fsm_state == ST_IDLE);

    pmc_src_hold #(.SRC_W(SRC_W)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .track_i (src_track),
        .src_i   (clk_src_i),
        .src_o   (clk_src_o)
    );

    pmc_gate_dec #(.NUM_PERIPH(NUM_PERIPH)) u_dec (
        .state_i     (fsm_state),
        .wdt_en_i    (wdt_en_i),
        .extclk_i    (periph_extclk_i),
        .cpu_en_o    (cpu_clk_en_o),
        .periph_en_o (periph_clk_en_o),
        .osc_en_o    (osc_en_o),
        .lprc_en_o   (lprc_en_o),
        .wdt_clr_o   (wdt_clr_o),
        .mon_en_o    (clk_mon_en_o),
        .mode_o      (dec_mode)
    );

    assign pm_mode_o    = dec_mode;
    assign wake_cause_o = fsm_cause;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
// Assertion checker for the power-mode controller, bound to the top.
// Assumes: sampled on the controller clock with synchronous reset.
module pwr_mode_ctrl_chk
    import pwr_mode_pkg::*;
#(
    parameter int SRC_W      = 3,
    parameter int NUM_PERIPH = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_vld_i,
    input logic                  irq_pend_i,
    input logic                  wdt_en_i,
    input logic [NUM_PERIPH-1:0] periph_extclk_i,
    input logic                  cpu_clk_en_o,
    input logic [NUM_PERIPH-1:0] periph_clk_en_o,
    input logic                  osc_en_o,
    input logic                  lprc_en_o,
    input logic                  wdt_clr_o,
    input logic                  clk_mon_en_o,
    input logic [SRC_W-1:0]      clk_src_o,
    input logic [1:0]            wake_cause_o,
    input logic [1:0]            pm_mode_o,
    input pm_state_e             fsm_state
);

    AST_ENTRY_CLOCKS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_SLP_ENTRY |-> cpu_clk_en_o && osc_en_o && pm_mode_o == 2'b00); // R1
    AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_SLEEP |-> !cpu_clk_en_o && !osc_en_o); // R1
    AST_IDLE_GATING: assert property (@(posedge clk) disable iff (!rst_n)
        pm_mode_o == 2'b01 |-> !cpu_clk_en_o && osc_en_o && (&periph_clk_en_o)); // R2
    AST_WDT_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_o |=> !wdt_clr_o && pm_mode_o == 2'b10); // R4
    AST_LPRC_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        pm_mode_o == 2'b10 |-> lprc_en_o == wdt_en_i); // R5
    AST_CLKMON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pm_mode_o == 2'b10 |-> !clk_mon_en_o); // R6
    AST_PERIPH_EXTCLK: assert property (@(posedge clk) disable iff (!rst_n)
        pm_mode_o == 2'b10 |-> periph_clk_en_o == periph_extclk_i); // R7
    AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_SLEEP || fsm_state == ST_SLP_WAKE) |=> $stable(clk_src_o)); // R8
    AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_RUN && req_vld_i && irq_pend_i) |=> fsm_state == ST_RUN); // R10
    AST_WAKE_OSC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_SLP_WAKE |-> osc_en_o && !cpu_clk_en_o); // R11
    AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_SLP_WAKE |=> fsm_state == ST_RUN && cpu_clk_en_o); // R11
    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_RUN && !(req_vld_i && !irq_pend_i)) |=> $stable(wake_cause_o)); // R12

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.SRC_W(SRC_W), .NUM_PERIPH(NUM_PERIPH)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_vld_i       (req_vld_i),
    .irq_pend_i      (irq_pend_i),
    .wdt_en_i        (wdt_en_i),
    .periph_extclk_i (periph_extclk_i),
    .cpu_clk_en_o    (cpu_clk_en_o),
    .periph_clk_en_o (periph_clk_en_o),
    .osc_en_o        (osc_en_o),
    .lprc_en_o       (lprc_en_o),
    .wdt_clr_o       (wdt_clr_o),
    .clk_mon_en_o    (clk_mon_en_o),
    .clk_src_o       (clk_src_o),
    .wake_cause_o    (wake_cause_o),
    .pm_mode_o       (pm_mode_o),
    .fsm_state       (fsm_state)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
// Self-checking bench for the power-mode controller.
module pwr_mode_ctrl_tb_top;

    localparam int SRC_W = 3;
    localparam int NP    = 4;

    // Vector: {op, wdt_en, wake_kind[1:0], src[2:0], extclk[3:0]}
    // op 1 = sleep, 0 = idle; wake_kind 1 irq, 2 watchdog, 3 both.
    localparam int NVEC = 6;
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 2'd1, 3'b101, 4'b0000},
        {1'b1, 1'b0, 2'd2, 3'b010, 4'b1010},
        {1'b0, 1'b1, 2'd1, 3'b011, 4'b0000},
        {1'b1, 1'b1, 2'd3, 3'b111, 4'b0101},
        {1'b0, 1'b0, 2'd2, 3'b001, 4'b1111},
        {1'b1, 1'b0, 2'd1, 3'b110, 4'b1111}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_vld = 1'b0, req_op = 1'b0, irq = 1'b0, wdt_tmo = 1'b0, wdt_en = 1'b0;
    logic [SRC_W-1:0] clk_src = 3'b101;
    logic [NP-1:0]   extclk = '0;
    logic            cpu_en, osc_en, lprc_en, wdt_clr, mon_en;
    logic [NP-1:0]   per_en;
    logic [SRC_W-1:0] src_out;
    logic [1:0]      cause, mode;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwr_mode_ctrl #(.SRC_W(SRC_W), .NUM_PERIPH(NP)) dut_i (
        .clk (clk), .rst_n (rst_n), .req_vld_i (req_vld), .req_op_i (req_op),
        .irq_pend_i (irq), .wdt_tmo_i (wdt_tmo), .wdt_en_i (wdt_en),
        .clk_src_i (clk_src), .periph_extclk_i (extclk),
        .cpu_clk_en_o (cpu_en), .periph_clk_en_o (per_en), .osc_en_o (osc_en),
        .lprc_en_o (lprc_en), .wdt_clr_o (wdt_clr), .clk_mon_en_o (mon_en),
        .clk_src_o (src_out), .wake_cause_o (cause), .pm_mode_o (mode)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // Full Run-mode output set (R9 and return-to-Run checks).
    task automatic chk_run(input string rq);
        chk(rq, "mode", int'(mode), 0);
        chk(rq, "cpu", int'(cpu_en), 1);
        chk(rq, "osc", int'(osc_en), 1);
        chk(rq, "lprc", int'(lprc_en), 1);
        chk(rq, "mon", int'(mon_en), 1);
        chk(rq, "periph", int'(per_en), 15);
        chk(rq, "wdtclr", int'(wdt_clr), 0);
    endtask

    // Bring the block to Sleep from Run (two steps).
    task automatic go_sleep();
        req_vld = 1'b1; req_op = 1'b1;
        step();
        req_vld = 1'b0;
        step();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // ---- reset state (R9)
        step(); step();
        chk_run("R9");
        chk("R9", "cause", int'(cause), 3);
        chk("R9", "src", int'(src_out), 0);
        rst_n = 1'b1;
        step();
        chk("R8", "src follows", int'(src_out), 5);

        // ---- vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic       v_op, v_wdt;
            logic [1:0] v_wk;
            logic [2:0] v_src;
            logic [3:0] v_ext;
            int         exp_cause;
            {v_op, v_wdt, v_wk, v_src, v_ext} = VEC[i];
            exp_cause = (v_wk == 2'd2) ? 2 : 1;
            wdt_en = v_wdt; extclk = v_ext; clk_src = v_src;
            req_vld = 1'b1; req_op = v_op;
            step();
            req_vld = 1'b0;
            chk("R12", "cause cleared", int'(cause), 0);
            if (v_op) begin
                chk("R1", "entry mode", int'(mode), 0);
                chk("R1", "entry cpu", int'(cpu_en), 1);
                chk("R1", "entry osc", int'(osc_en), 1);
                chk("R4", "wdt clr", int'(wdt_clr), int'(v_wdt));
                clk_src = ~v_src;
                step();
                chk("R1", "sleep mode", int'(mode), 2);
                chk("R1", "sleep cpu", int'(cpu_en), 0);
                chk("R1", "sleep osc", int'(osc_en), 0);
                chk("R4", "clr gone", int'(wdt_clr), 0);
                chk("R5", "lprc", int'(lprc_en), int'(v_wdt));
                chk("R6", "mon off", int'(mon_en), 0);
                chk("R7", "periph", int'(per_en), int'(v_ext));
                step();
                chk("R8", "src held", int'(src_out), int'(v_src));
                irq = v_wk[0]; wdt_tmo = v_wk[1];
                step();
                irq = 1'b0; wdt_tmo = 1'b0;
                chk("R11", "wake osc", int'(osc_en), 1);
                chk("R11", "wake cpu", int'(cpu_en), 0);
                chk("R11", "wake mode", int'(mode), 2);
                chk("R12", "cause", int'(cause), exp_cause);
                step();
                chk_run("R11");
                chk("R8", "src restored", int'(src_out), int'(v_src));
                step();
                chk("R8", "src follows", int'(src_out), int'(3'(~v_src)));
            end else begin
                chk("R2", "idle mode", int'(mode), 1);
                chk("R2", "idle cpu", int'(cpu_en), 0);
                chk("R2", "idle osc", int'(osc_en), 1);
                chk("R2", "idle periph", int'(per_en), 15);
                chk("R6", "idle mon", int'(mon_en), 1);
                chk("R5", "idle lprc", int'(lprc_en), 1);
                chk("R4", "idle clr", int'(wdt_clr), 0);
                step();
                irq = v_wk[0]; wdt_tmo = v_wk[1];
                step();
                irq = 1'b0; wdt_tmo = 1'b0;
                chk("R3", "idle wake mode", int'(mode), 0);
                chk("R3", "idle wake cpu", int'(cpu_en), 1);
                chk("R12", "cause", int'(cause), exp_cause);
            end
            step();
            chk("R12", "cause holds", int'(cause), exp_cause);
        end

        // ---- R10: request blocked by pending interrupt (last cause = 01)
        wdt_en = 1'b1; irq = 1'b1; req_vld = 1'b1; req_op = 1'b1;
        step();
        req_vld = 1'b0;
        chk("R10", "no entry clr", int'(wdt_clr), 0);
        chk("R10", "mode", int'(mode), 0);
        step();
        irq = 1'b0;
        chk("R10", "cpu", int'(cpu_en), 1);
        chk("R10", "osc", int'(osc_en), 1);
        chk("R10", "cause kept", int'(cause), 1);

        // ---- R13: sleep request while in Idle is ignored
        req_vld = 1'b1; req_op = 1'b0;
        step();
        req_op = 1'b1;
        step();
        req_vld = 1'b0;
        chk("R13", "mode stays idle", int'(mode), 1);
        chk("R13", "osc on", int'(osc_en), 1);
        chk("R13", "no clr", int'(wdt_clr), 0);
        wdt_tmo = 1'b1;
        step();
        wdt_tmo = 1'b0;
        chk("R3", "wdt wake from idle", int'(mode), 0);

        // ---- Sleep: live input changes and a request inside Sleep
        extclk = 4'b0011; wdt_en = 1'b1;
        go_sleep();
        chk("R7", "periph a", int'(per_en), 3);
        extclk = 4'b1100;
        wdt_en = 1'b0;
        req_vld = 1'b1; req_op = 1'b0;
        step();
        req_vld = 1'b0;
        chk("R7", "periph b", int'(per_en), 12);
        chk("R5", "lprc off", int'(lprc_en), 0);
        chk("R13", "still sleep", int'(mode), 2);
        chk("R13", "cause kept", int'(cause), 0);

        // ---- R3: reset during Sleep
        rst_n = 1'b0;
        step();
        chk_run("R3");
        chk("R3", "cause reset", int'(cause), 3);
        rst_n = 1'b1;
        step();
        chk("R3", "run after reset", int'(mode), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule